// File: doc/BRIEF.md
# Cascaded Multi-Rate Countdown Timer Bank

This block holds thirty-two byte-wide countdown timers arranged as four rate groups of eight. A free-running counter is compared with a compare register; each time the two match, the compare register advances by a fixed step and one base tick is produced. With the defaults the step is 8000 counts of a 2 MHz count, so the base tick comes every 4 ms. Three prescalers are chained behind the base tick. The first divides it by 25 to give 100 ms. The second divides that by 10 to give 1 s. The third divides that by 60 to give 1 min.

Each group's timers step down by one on their group's tick. A timer that already holds zero stays at zero. Software loads a timer with N through the write port and then polls it through the read port or the zero vector. The timer reaches zero N group periods after the load. For example, a load of 25 into a 100 ms timer expires after 2.5 s.

Top module: `tmrbank_top`

## Requirements
- R1: A synchronous reset clears every timer to 0, sets every zero-vector bit to 1, loads each prescaler with its divide value and restarts the base counter.
- R2: Base ticks occur exactly every STEP counts, including across the wraparound of the CNT_W-bit counter. The first base tick comes STEP counts after reset. A group-0 timer loaded with N just at a base tick reads 1 after N*STEP-1 further cycles and 0 after N*STEP.
- R3: Group 1 timers decrement once per DIV1 base ticks.
- R4: Group 2 timers decrement once per DIV2 group-1 ticks.
- R5: Group 3 timers decrement once per DIV3 group-2 ticks, and only on a group-2 tick that empties the group-3 prescaler.
- R6: A timer that holds 0 stays at 0 on its group's ticks and never wraps.
- R7: A write in the same cycle as the target timer's group tick stores the written value without decrementing it. Timers that are not written still decrement on that tick.
- R8: Bit i of `zeroVec` is 1 exactly when timer i holds 0.
- R9: `rdData` shows the current value of timer `rdIdx` without delay. No timer changes by more than one step per cycle unless it is written.
- R10: Timer index bits [4:3] select the rate group (0 = base rate, 3 = slowest), and bits [2:0] select the timer within the group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; also the count clock of the free-running counter |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Load strobe for the timer at `wrIdx` |
| wrIdx | input | 5 | Timer index written; [4:3] rate group, [2:0] timer |
| wrData | input | 8 | Value loaded into the timer |
| rdIdx | input | 5 | Timer index read |
| rdData | output | 8 | Current value of timer `rdIdx` |
| zeroVec | output | 32 | Per-timer zero flags, bit i for timer i |

## Verification
The hardest case to reach from the ports is a host write that lands in exactly the cycle of its group's tick, because no tick is visible at the ports. The bench keeps its own count of cycles since reset and derives from it when the next base tick falls. It drives the write in that cycle, then counts whole base periods to catch the timer at 1 and then at 0. The bench also shortens the step, the counter width and the divide values so that the slowest group ticks many times and the counter wraps at a step that does not divide its range.

// File: rtl/tmrbank_pkg.sv
package tmrbank_pkg;
  localparam int NUM_RATES = 4;

  typedef struct packed {
    logic [NUM_RATES-1:0] rateTick;
  } rateStrb_t;
endpackage

// File: rtl/tmrbank_ctrl.sv
module tmrbank_ctrl
  import tmrbank_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int STEP  = 8000,
  parameter int DIV1  = 25,
  parameter int DIV2  = 10,
  parameter int DIV3  = 60,
  parameter int PRE_W = 8
) (
  input  logic      clk,
  input  logic      rst,
  output rateStrb_t strb
);
  function automatic int divOf(int stage);
    case (stage)
      1:       return DIV1;
      2:       return DIV2;
      default: return DIV3;
    endcase
  endfunction

  logic [CNT_W-1:0] freeCnt;
  logic [CNT_W-1:0] cmpVal;
  logic [NUM_RATES-1:0] tick;

  assign tick[0] = (freeCnt == cmpVal);

  always_ff @(posedge clk) begin
    if (rst) begin
      freeCnt <= '0;
      cmpVal  <= CNT_W'(STEP);
    end else begin
      freeCnt <= freeCnt + 1'b1;
      if (tick[0]) cmpVal <= cmpVal + CNT_W'(STEP);
    end
  end

  for (genvar g = 1; g < NUM_RATES; g++) begin : gPre
    localparam int DIVG = divOf(g);
    logic [PRE_W-1:0] preCnt;
    always_ff @(posedge clk) begin
      if (rst) preCnt <= PRE_W'(DIVG);
      else if (tick[g-1]) preCnt <= (preCnt == PRE_W'(1)) ? PRE_W'(DIVG) : preCnt - 1'b1;
    end
    assign tick[g] = tick[g-1] && (preCnt == PRE_W'(1));
  end

  assign strb.rateTick = tick;
endmodule

// File: rtl/tmrbank_dp.sv
module tmrbank_dp
  import tmrbank_pkg::*;
#(
  parameter int PER_GRP = 8,
  parameter int TMR_W   = 8,
  localparam int NT     = NUM_RATES * PER_GRP,
  localparam int IDX_W  = $clog2(NT)
) (
  input  logic             clk,
  input  logic             rst,
  input  rateStrb_t        strb,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [TMR_W-1:0] wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [TMR_W-1:0] rdData,
  output logic [NT-1:0]    zeroVec
);
  logic [TMR_W-1:0] tmrVal [NT];

  for (genvar i = 0; i < NT; i++) begin : gTmr
    localparam int GRP = i / PER_GRP;
    logic hit;
    assign hit = wrEn && (wrIdx == IDX_W'(i));
    always_ff @(posedge clk) begin
      if (rst) tmrVal[i] <= '0;
      else if (hit) tmrVal[i] <= wrData;
      else if (strb.rateTick[GRP] && (tmrVal[i] != '0)) tmrVal[i] <= tmrVal[i] - 1'b1;
    end
    assign zeroVec[i] = (tmrVal[i] == '0);
  end

  assign rdData = tmrVal[rdIdx];
endmodule

// File: rtl/tmrbank_top.sv
module tmrbank_top
  import tmrbank_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int STEP    = 8000,
  parameter int DIV1    = 25,
  parameter int DIV2    = 10,
  parameter int DIV3    = 60,
  parameter int PRE_W   = 8,
  parameter int PER_GRP = 8,
  parameter int TMR_W   = 8,
  localparam int NT     = NUM_RATES * PER_GRP,
  localparam int IDX_W  = $clog2(NT)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [TMR_W-1:0] wrData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic [TMR_W-1:0] rdData,
  output logic [NT-1:0]    zeroVec
);
  rateStrb_t strb;

  tmrbank_ctrl #(
    .CNT_W(CNT_W), .STEP(STEP), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3), .PRE_W(PRE_W)
  ) uCtrl (
    .clk(clk), .rst(rst), .strb(strb)
  );

  tmrbank_dp #(
    .PER_GRP(PER_GRP), .TMR_W(TMR_W)
  ) uDp (
    .clk(clk), .rst(rst), .strb(strb),
    .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .zeroVec(zeroVec)
  );
endmodule

// File: rtl/tmrbank_chk.sv
module tmrbank_chk
  import tmrbank_pkg::*;
#(
  parameter int STEP  = 8000,
  parameter int DIV1  = 25,
  parameter int DIV2  = 10,
  parameter int DIV3  = 60,
  parameter int NT    = 32,
  parameter int IDX_W = 5,
  parameter int TMR_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic [IDX_W-1:0] wrIdx,
  input logic [TMR_W-1:0] wrData,
  input logic [IDX_W-1:0] rdIdx,
  input logic [TMR_W-1:0] rdData,
  input logic [NT-1:0]    zeroVec,
  input rateStrb_t        strb
);
  logic [31:0] baseGap;
  always_ff @(posedge clk) begin
    if (rst) baseGap <= '0;
    else if (strb.rateTick[0]) baseGap <= 32'd1;
    else baseGap <= baseGap + 32'd1;
  end

  // R1
  reset_clears_chk: assert property (@(posedge clk) rst |=> (zeroVec == {NT{1'b1}}));

  // R2
  base_period_chk: assert property (@(posedge clk) disable iff (rst)
    strb.rateTick[0] |-> (baseGap == 32'(STEP)));

  // R2
  base_gap_bound_chk: assert property (@(posedge clk) disable iff (rst)
    baseGap <= 32'(STEP));

  for (genvar g = 1; g < NUM_RATES; g++) begin : gStage
    localparam int DIVG = (g == 1) ? DIV1 : (g == 2) ? DIV2 : DIV3;
    logic [31:0] lowCnt;
    always_ff @(posedge clk) begin
      if (rst) lowCnt <= '0;
      else if (strb.rateTick[g-1]) lowCnt <= strb.rateTick[g] ? 32'd0 : lowCnt + 32'd1;
    end
    // R3, R4, R5: one instance per cascaded stage
    stage_ratio_chk: assert property (@(posedge clk) disable iff (rst)
      strb.rateTick[g] |-> (lowCnt == 32'(DIVG - 1)));
  end

  for (genvar i = 0; i < NT; i++) begin : gZero
    // R6
    zero_sticks_chk: assert property (@(posedge clk) disable iff (rst)
      (zeroVec[i] && !(wrEn && wrIdx == IDX_W'(i))) |=> zeroVec[i]);
  end

  // R7
  write_lands_chk: assert property (@(posedge clk) disable iff (rst)
    wrEn |=> (zeroVec[$past(wrIdx)] == ($past(wrData) == '0)));

  // R9
  single_step_chk: assert property (@(posedge clk) disable iff (rst)
    !wrEn |=> ((rdIdx != $past(rdIdx)) || (rdData == $past(rdData)) ||
               (rdData == $past(rdData) - TMR_W'(1))));
endmodule

bind tmrbank_top tmrbank_chk #(
  .STEP(STEP), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3),
  .NT(NT), .IDX_W(IDX_W), .TMR_W(TMR_W)
) uChk (.*);

// File: tb/tb_tmrbank_top.sv
`timescale 1ns/1ps
module tb_tmrbank_top;
  localparam int CNT_W = 5;
  localparam int STEP  = 6;
  localparam int DIV1  = 3;
  localparam int DIV2  = 2;
  localparam int DIV3  = 3;
  localparam int NT    = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0;
  logic [4:0] wrIdx = '0;
  logic [7:0] wrData = '0;
  logic [4:0] rdIdx = '0;
  logic [7:0] rdData;
  logic [NT-1:0] zeroVec;

  int compared = 0;
  int mismatched = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  tmrbank_top #(
    .CNT_W(CNT_W), .STEP(STEP), .DIV1(DIV1), .DIV2(DIV2), .DIV3(DIV3)
  ) dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrIdx(wrIdx), .wrData(wrData),
    .rdIdx(rdIdx), .rdData(rdData), .zeroVec(zeroVec)
  );

  // Reference model built from the requirements
  logic [7:0] refT [NT];
  int refCnt;
  int baseCnt;
  always @(posedge clk) begin
    bit f0, f1, f2, f3;
    if (rst) begin
      refCnt = 0;
      baseCnt = 0;
      for (int i = 0; i < NT; i++) refT[i] = 8'd0;
    end else begin
      f0 = (refCnt > 0) && (refCnt % STEP == 0);
      refCnt++;
      if (f0) baseCnt++;
      f1 = f0 && (baseCnt % DIV1 == 0);
      f2 = f1 && (baseCnt % (DIV1 * DIV2) == 0);
      f3 = f2 && (baseCnt % (DIV1 * DIV2 * DIV3) == 0);
      for (int i = 0; i < NT; i++) begin
        bit fg;
        fg = (i / 8 == 0) ? f0 : (i / 8 == 1) ? f1 : (i / 8 == 2) ? f2 : f3;
        if (wrEn && wrIdx == 5'(i)) refT[i] = wrData;
        else if (fg && refT[i] != 8'd0) refT[i] = refT[i] - 8'd1;
      end
    end
  end

  task automatic check(string tag, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // Scoreboard
  typedef struct {
    int idx;
    int exp;
    string tag;
  } item_t;
  item_t sbq[$];

  task automatic probe(int idx, string tag);
    item_t it;
    rdIdx = 5'(idx);
    it.idx = idx;
    it.exp = refT[idx];
    it.tag = tag;
    sbq.push_back(it);
  endtask

  initial begin
    forever begin
      item_t it;
      wait (sbq.size() != 0);
      #0.5;
      it = sbq.pop_front();
      check(it.tag, rdData, it.exp);
    end
  end

  // R8: zero vector against the model on every cycle after reset
  always @(negedge clk) begin
    if (!rst && !finished) begin
      logic [NT-1:0] expZ;
      for (int i = 0; i < NT; i++) expZ[i] = (refT[i] == 8'd0);
      check("R8 zeroVec", int'(zeroVec), int'(expZ));
    end
  end

  task automatic wr(int idx, int val);
    @(negedge clk);
    wrEn = 1'b1; wrIdx = 5'(idx); wrData = 8'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic finish_run();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    mismatched++;
    $display("FAIL watchdog: got 0 expected 1 (run completion)");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state seen through the ports
    check("R1 zeroVec after reset", int'(zeroVec), -1);
    rdIdx = 5'd17; #0.5;
    check("R1 rdData after reset", rdData, 0);
    rst = 1'b0;

    // R10 loads across groups by index bits [4:3]
    wr(8, 4);
    wr(16, 3);
    wr(24, 2);
    wr(13, 200);
    wr(5, 9);
    wr(12, 9);
    wr(3, 5);
    wr(31, 255);

    // R7: write lands in the very cycle of a base tick
    @(negedge clk);
    while (!(refCnt > 0 && refCnt % STEP == 0)) @(negedge clk);
    begin
      int before3;
      before3 = refT[3];
      wrEn = 1'b1; wrIdx = 5'd2; wrData = 8'd3;
      @(negedge clk);
      wrEn = 1'b0;
      rdIdx = 5'd2; #0.5;
      check("R7 written value not decremented", rdData, 3);
      rdIdx = 5'd3; #0.5;
      check("R7 neighbour still decrements", rdData, (before3 > 0) ? before3 - 1 : 0);
    end
    // R2: timer 2 counts whole base periods
    repeat (3 * STEP - 1) @(negedge clk);
    rdIdx = 5'd2; #0.5;
    check("R2 one period before expiry", rdData, 1);
    @(negedge clk);
    #0.5;
    check("R2 expired after N periods", rdData, 0);
    // R6: stays at zero through further ticks
    repeat (5 * STEP) @(negedge clk);
    #0.5;
    check("R6 zero timer holds", rdData, 0);
    rdIdx = 5'd1; #0.5;
    check("R6 never-loaded timer holds", rdData, 0);

    // Long run, scanning every timer against the model
    for (int c = 0; c < 6000; c++) begin
      @(negedge clk);
      case ((c % 32) / 8)
        0: probe(c % 32, "R2 group0 timer");
        1: probe(c % 32, "R3 group1 timer");
        2: probe(c % 32, "R4 group2 timer");
        default: probe(c % 32, "R5 group3 timer");
      endcase
      if (c == 900)  wr(31, 7);
      if (c == 1500) wr(20, 6);
      if (c == 2500) wr(10, 1);
    end

    @(negedge clk); probe(13, "R10 index 13 in group1");
    @(negedge clk); probe(12, "R10 index 12 in group1");
    @(negedge clk); probe(5, "R9 read port group0");
    @(negedge clk);
    // R8: direct zero flag after a load of 0
    wr(31, 0);
    #0.5;
    check("R8 zero flag after zero load", int'(zeroVec[31]), 1);
    wr(30, 1);
    #0.5;
    check("R8 flag clear after nonzero load", int'(zeroVec[30]), 0);
    @(negedge clk);
    finish_run();
  end
endmodule